// File: doc/BRIEF.md
# Cycle-Stealing Multi-Channel Byte Mover

This block moves bytes between any two addresses of a shared bus with a 16-bit address and 8-bit data, so that peripherals are served without a CPU interrupt per byte. Each channel has four parts: a source pointer, a destination pointer, a remaining-length counter, and a control word. The control word sets enable, whether each pointer steps, and completion-interrupt enable. A channel with its enable set moves one byte each time its peripheral request line is high and the bus is won. The sources and destinations can be memory locations or peripheral data registers.

The engine asks for the bus with a request/grant handshake. A bandwidth cap, selectable from 25% to 100%, limits how many bus cycles it takes. Every byte costs exactly one read clock and one write clock. A global wait-enable input decides whether the engine keeps working while the CPU is in low-power wait. The channel count is a parameter from 1 to 7.

Top module: `dma_steal_top`

## Requirements
- R1: A byte moves in exactly two consecutive clocks. The first is a read clock with `bus_rd`=1 and `bus_addr` set to the source pointer. The second is a write clock with `bus_wr`=1, `bus_addr` set to the destination pointer, and `bus_wdata` equal to the byte read.
- R2: After each byte, a pointer steps up by one if its step bit is set, and stays fixed if the bit is clear. The control field (`cfg_fld`=3) has these bits: bit0 enable, bit1 source step, bit2 destination step, bit3 interrupt enable, bit4 done-clear. Other fields: `cfg_fld` 0 = source, 1 = destination, 2 = length.
- R3: A length value of 1 to 255 moves that many bytes, and 0 moves 256. After the last byte, the channel clears its enable and sets its `done` bit.
- R4: `bw_sel` gives the number of transfers allowed per aligned 8-clock window: 0 allows 1, 1 allows 2, 2 allows 3. Windows are counted from reset release. A transfer belongs to the window of the clock before its read clock. `bw_sel`=3 lets transfers run back to back with no idle clock.
- R5: Among enabled channels with a pending request, the lowest-numbered channel wins. A byte that has started always finishes before the next arbitration.
- R6: A read clock only follows a clock in which both `bus_req` and `bus_grant` are high. While grant is low, nothing moves and `bus_req` stays high. `bus_req` is low when no transfer is eligible or the window budget is spent.
- R7: `irq[i]` is high exactly when `done[i]` is set and channel i has interrupt enable set.
- R8: A control write with bit4=1 clears `done`. A control write with bit0=1 also clears `done`. If a block completes on the same clock as such a write, `done` ends up set.
- R9: While `cpu_wait`=1 and `wait_en`=0, no transfer starts and `bus_req` stays low. With `wait_en`=1, transfers continue during wait.
- R10: After reset, `bus_req`, `bus_rd`, `bus_wr`, `done` and `irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_we | input | 1 | Channel field write strobe |
| cfg_chan | input | CHW | Channel selected for the write |
| cfg_fld | input | 2 | Field: 0 source, 1 destination, 2 length, 3 control |
| cfg_wdata | input | AW | Write data |
| bw_sel | input | 2 | Bandwidth cap: 25/50/75/100 % |
| wait_en | input | 1 | Allow transfers during CPU wait |
| cpu_wait | input | 1 | CPU is in low-power wait |
| dreq | input | NCH | Per-channel peripheral request |
| bus_req | output | 1 | Bus request to the CPU |
| bus_grant | input | 1 | Bus granted by the CPU |
| bus_addr | output | AW | Bus address |
| bus_rd | output | 1 | Read clock strobe |
| bus_wr | output | 1 | Write clock strobe |
| bus_rdata | input | DW | Read data returned in the read clock |
| bus_wdata | output | DW | Write data |
| done | output | NCH | Per-channel block-complete flag |
| irq | output | NCH | Per-channel completion interrupt |

## Verification
Two events can land on the same clock edge: a channel's final write, which sets `done`, and a software control write that clears `done`. The bench provokes this by watching for the write clock of a one-byte block and driving a done-clear write into that same clock. It then requires `done` to read 1 on the next clock, and to read 0 only after a separate clear write. Arbitration against a spent bandwidth budget is the other overlap. It is judged by counting read clocks per aligned window against the cap, while requests stay high throughout.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RD   = 2'd1,
    SEQ_WR   = 2'd2
  } seq_state_t;

  localparam logic [1:0] FLD_SRC = 2'd0;
  localparam logic [1:0] FLD_DST = 2'd1;
  localparam logic [1:0] FLD_LEN = 2'd2;
  localparam logic [1:0] FLD_CTL = 2'd3;

  localparam int CTL_EN   = 0;
  localparam int CTL_SINC = 1;
  localparam int CTL_DINC = 2;
  localparam int CTL_IEN  = 3;
  localparam int CTL_CLR  = 4;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_pkg::*;
#(
  parameter int AW   = 16,
  parameter int LENW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_fld,
  input  logic [AW-1:0] wr_data,
  input  logic          step,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output logic          active,
  output logic          last,
  output logic          done,
  output logic          irq
);
  localparam int RW = LENW + 1;

  logic [RW-1:0] rem, rem_n;
  logic [AW-1:0] src_n, dst_n;
  logic en, en_n, sinc, sinc_n, dinc, dinc_n, ien, ien_n, done_n;
  logic wr_ctl, fin;

  assign wr_ctl = wr_en && (wr_fld == FLD_CTL);
  assign fin    = step && (rem == RW'(1));

  always_comb begin
    src_n  = src;
    dst_n  = dst;
    rem_n  = rem;
    en_n   = en;
    sinc_n = sinc;
    dinc_n = dinc;
    ien_n  = ien;
    done_n = done;
    if (wr_en && wr_fld == FLD_SRC)      src_n = wr_data;
    else if (step && sinc)               src_n = src + AW'(1);
    if (wr_en && wr_fld == FLD_DST)      dst_n = wr_data;
    else if (step && dinc)               dst_n = dst + AW'(1);
    if (wr_en && wr_fld == FLD_LEN) begin
      if (wr_data[LENW-1:0] == '0) rem_n = {1'b1, {LENW{1'b0}}};
      else                         rem_n = {1'b0, wr_data[LENW-1:0]};
    end else if (step) begin
      rem_n = rem - RW'(1);
    end
    if (wr_ctl) begin
      en_n   = wr_data[CTL_EN];
      sinc_n = wr_data[CTL_SINC];
      dinc_n = wr_data[CTL_DINC];
      ien_n  = wr_data[CTL_IEN];
      if (wr_data[CTL_CLR] || wr_data[CTL_EN]) done_n = 1'b0;
    end
    if (fin) begin
      en_n   = 1'b0;
      done_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src  <= '0;
      dst  <= '0;
      rem  <= '0;
      en   <= 1'b0;
      sinc <= 1'b0;
      dinc <= 1'b0;
      ien  <= 1'b0;
      done <= 1'b0;
    end else begin
      src  <= src_n;
      dst  <= dst_n;
      rem  <= rem_n;
      en   <= en_n;
      sinc <= sinc_n;
      dinc <= dinc_n;
      ien  <= ien_n;
      done <= done_n;
    end
  end

  assign active = en && (rem != '0);
  assign last   = (rem == RW'(1));
  assign irq    = done && ien;

  // A byte is only retired on a channel that still has length left (R3)
  assert_step_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (rem != '0));

  // done only rises after a retired byte (R8)
  assert_done_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(step));
endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int NCH = 4
) (
  input  logic [NCH-1:0] req,
  output logic [NCH-1:0] gnt,
  output logic           any
);
  always_comb begin
    gnt = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) gnt = NCH'(1) << i;
    end
  end

  assign any = |req;
endmodule

// File: rtl/dma_bw_limiter.sv
module dma_bw_limiter #(
  parameter int WIN = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bw_sel,
  input  logic       start,
  output logic       allow
);
  localparam int PW   = $clog2(WIN);
  localparam int HALF = WIN / 2;

  logic [PW-1:0] wcnt, wcnt_n, used, used_n, budget;
  logic          full, wrap;

  always_comb begin
    int b;
    b      = ((int'(bw_sel) + 1) * HALF) / 4;
    budget = PW'(b);
  end

  assign full  = (bw_sel == 2'd3);
  assign wrap  = (wcnt == PW'(WIN - 1));
  assign allow = full || (used < budget);

  always_comb begin
    wcnt_n = wrap ? '0 : wcnt + PW'(1);
    used_n = wrap ? '0 : used + PW'(start);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt <= '0;
      used <= '0;
    end else begin
      wcnt <= wcnt_n;
      used <= used_n;
    end
  end

  // The sequencer never starts past the budget of a capped window (R4)
  assert_budget_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !full) |-> (used < budget));
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
  import dma_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int DW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] win_oh,
  input  logic           any_elig,
  input  logic           allow,
  input  logic           hold,
  input  logic           grant,
  input  logic [AW-1:0]  cur_src,
  input  logic [AW-1:0]  cur_dst,
  input  logic [DW-1:0]  rdata,
  output logic           bus_req,
  output logic           bus_rd,
  output logic           bus_wr,
  output logic [AW-1:0]  bus_addr,
  output logic [DW-1:0]  bus_wdata,
  output logic           start,
  output logic [NCH-1:0] cur_oh,
  output logic [NCH-1:0] step_oh
);
  seq_state_t     st, st_n;
  logic [NCH-1:0] cur_n;
  logic [DW-1:0]  rbuf, rbuf_n;
  logic           can_issue, free;

  assign can_issue = any_elig && allow && !hold;
  assign free      = (st == SEQ_IDLE) || (st == SEQ_WR);
  assign start     = free && can_issue && grant;

  always_comb begin
    st_n   = st;
    cur_n  = cur_oh;
    rbuf_n = rbuf;
    case (st)
      SEQ_IDLE, SEQ_WR: st_n = start ? SEQ_RD : SEQ_IDLE;
      SEQ_RD:           st_n = SEQ_WR;
      default:          st_n = SEQ_IDLE;
    endcase
    if (start)         cur_n  = win_oh;
    if (st == SEQ_RD)  rbuf_n = rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= SEQ_IDLE;
      cur_oh <= '0;
      rbuf   <= '0;
    end else begin
      st     <= st_n;
      cur_oh <= cur_n;
      rbuf   <= rbuf_n;
    end
  end

  assign bus_rd    = (st == SEQ_RD);
  assign bus_wr    = (st == SEQ_WR);
  assign bus_req   = bus_rd || bus_wr || can_issue;
  assign bus_addr  = bus_rd ? cur_src : (bus_wr ? cur_dst : '0);
  assign bus_wdata = rbuf;
  assign step_oh   = bus_wr ? cur_oh : '0;

  // Read clock is always followed by its write clock (R1)
  assert_rd_then_wr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_wr);

  // A write clock is always preceded by a read clock (R1)
  assert_wr_after_rd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> $past(bus_rd));

  // The bus is taken only after request and grant were both high (R6)
  assert_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> $past(bus_req && grant));
endmodule

// File: rtl/dma_steal_top.sv
module dma_steal_top
  import dma_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int AW   = 16,
  parameter int DW   = 8,
  parameter int LENW = 8,
  parameter int WIN  = 8,
  parameter int CHW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [CHW-1:0] cfg_chan,
  input  logic [1:0]     cfg_fld,
  input  logic [AW-1:0]  cfg_wdata,
  input  logic [1:0]     bw_sel,
  input  logic           wait_en,
  input  logic           cpu_wait,
  input  logic [NCH-1:0] dreq,
  output logic           bus_req,
  input  logic           bus_grant,
  output logic [AW-1:0]  bus_addr,
  output logic           bus_rd,
  output logic           bus_wr,
  input  logic [DW-1:0]  bus_rdata,
  output logic [DW-1:0]  bus_wdata,
  output logic [NCH-1:0] done,
  output logic [NCH-1:0] irq
);
  logic [AW-1:0]  src_v [NCH];
  logic [AW-1:0]  dst_v [NCH];
  logic [NCH-1:0] act_v, last_v, elig, win_oh, cur_oh, step_oh;
  logic [AW-1:0]  cur_src, cur_dst;
  logic           any_elig, allow, start, hold;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dma_chan_regs #(.AW(AW), .LENW(LENW)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we && (cfg_chan == CHW'(i))),
      .wr_fld  (cfg_fld),
      .wr_data (cfg_wdata),
      .step    (step_oh[i]),
      .src     (src_v[i]),
      .dst     (dst_v[i]),
      .active  (act_v[i]),
      .last    (last_v[i]),
      .done    (done[i]),
      .irq     (irq[i])
    );
  end

  // A channel retiring its final byte this clock is no longer a candidate
  assign elig = act_v & dreq & ~(step_oh & last_v);
  assign hold = cpu_wait && !wait_en;

  dma_prio_arb #(.NCH(NCH)) u_arb (
    .req (elig),
    .gnt (win_oh),
    .any (any_elig)
  );

  dma_bw_limiter #(.WIN(WIN)) u_lim (
    .clk    (clk),
    .rst_n  (rst_n),
    .bw_sel (bw_sel),
    .start  (start),
    .allow  (allow)
  );

  always_comb begin
    cur_src = '0;
    cur_dst = '0;
    for (int i = 0; i < NCH; i++) begin
      cur_src = cur_src | (src_v[i] & {AW{cur_oh[i]}});
      cur_dst = cur_dst | (dst_v[i] & {AW{cur_oh[i]}});
    end
  end

  dma_xfer_seq #(.NCH(NCH), .AW(AW), .DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_oh    (win_oh),
    .any_elig  (any_elig),
    .allow     (allow),
    .hold      (hold),
    .grant     (bus_grant),
    .cur_src   (cur_src),
    .cur_dst   (cur_dst),
    .rdata     (bus_rdata),
    .bus_req   (bus_req),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .start     (start),
    .cur_oh    (cur_oh),
    .step_oh   (step_oh)
  );

  // No byte starts while the CPU waits unless wait operation is enabled (R9)
  assert_wait_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> $past(wait_en || !cpu_wait));

  // A write clock retires exactly one channel (R5)
  assert_one_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> $onehot(step_oh));
endmodule

// File: tb/sim_dma_steal_top.sv
`timescale 1ns/1ps
module sim_dma_steal_top;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_chan;
  logic [1:0]  cfg_fld;
  logic [15:0] cfg_wdata;
  logic [1:0]  bw_sel;
  logic        wait_en, cpu_wait, bus_grant;
  logic [3:0]  dreq;
  logic        bus_req, bus_rd, bus_wr;
  logic [15:0] bus_addr;
  logic [7:0]  bus_rdata, bus_wdata;
  logic [3:0]  done, irq;

  logic [7:0]  mem [256];
  logic [7:0]  model [256];

  int checks = 0;
  int fails  = 0;
  int cyc = 0;
  int rd_cnt, pair_err, maxw, curw, wcount, first_rd, last_rd, rd_idx;
  logic [15:0] rd_log [8];
  logic        prev_rd;

  always #2 clk = ~clk;

  dma_steal_top u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_chan(cfg_chan),
    .cfg_fld(cfg_fld), .cfg_wdata(cfg_wdata), .bw_sel(bw_sel),
    .wait_en(wait_en), .cpu_wait(cpu_wait), .dreq(dreq),
    .bus_req(bus_req), .bus_grant(bus_grant), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
    .bus_wdata(bus_wdata), .done(done), .irq(irq)
  );

  assign bus_rdata = bus_rd ? mem[bus_addr[7:0]] : 8'h00;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
    if (rst_n && bus_wr) mem[bus_addr[7:0]] <= bus_wdata;
  end

  // Bus monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_wr && !prev_rd) pair_err++;
      if (bus_rd) begin
        rd_cnt++;
        if (first_rd < 0) first_rd = cyc;
        last_rd = cyc;
        if (rd_idx < 8) begin rd_log[rd_idx] = bus_addr; rd_idx++; end
        if (((cyc - 1) >> 3) == curw) wcount++;
        else begin curw = (cyc - 1) >> 3; wcount = 1; end
        if (wcount > maxw) maxw = wcount;
      end
      prev_rd = bus_rd;
    end else begin
      prev_rd = 1'b0;
    end
  end

  function automatic logic [7:0] ival(input int a);
    return 8'(a * 7 + 3);
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr_stats();
    rd_cnt = 0; pair_err = 0; maxw = 0; curw = -1; wcount = 0;
    first_rd = -1; last_rd = -1; rd_idx = 0;
  endtask

  task automatic init_mem();
    for (int a = 0; a < 256; a++) begin
      mem[a] = ival(a);
      model[a] = ival(a);
    end
  endtask

  task automatic cfg(input int ch, input int fld, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_chan = 2'(ch); cfg_fld = 2'(fld); cfg_wdata = 16'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_done(input int ch, input int limit);
    int n = 0;
    while (!done[ch] && n < limit) begin @(negedge clk); n++; end
    chk(done[ch] == 1'b1, "R3 done", int'(done[ch]), 1);
  endtask

  // {ch, src, dst, len, sinc, dinc, bw}
  localparam logic [30:0] VEC [6] = '{
    {3'd0, 8'h00, 8'h40, 8'd8, 1'b1, 1'b1, 2'd3},
    {3'd1, 8'h10, 8'h50, 8'd5, 1'b1, 1'b1, 2'd0},
    {3'd2, 8'h20, 8'h60, 8'd6, 1'b1, 1'b1, 2'd1},
    {3'd3, 8'h30, 8'h70, 8'd7, 1'b1, 1'b1, 2'd2},
    {3'd0, 8'hF0, 8'h80, 8'd4, 1'b0, 1'b1, 2'd3},
    {3'd1, 8'h90, 8'hF8, 8'd3, 1'b1, 1'b0, 2'd3}
  };

  initial begin
    #600000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_chan = '0; cfg_fld = '0; cfg_wdata = '0;
    bw_sel = 2'd3; wait_en = 1'b0; cpu_wait = 1'b0; bus_grant = 1'b1; dreq = '0;
    prev_rd = 1'b0;
    clr_stats();
    init_mem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(bus_req == 1'b0 && bus_rd == 1'b0 && bus_wr == 1'b0, "R10 bus idle",
        int'({bus_req, bus_rd, bus_wr}), 0);
    chk(done == '0 && irq == '0, "R10 flags", int'({done, irq}), 0);

    // Table walk: transfers under several patterns and caps
    for (int v = 0; v < 6; v++) begin
      int ch, src, dst, len, n, mism;
      logic si, di;
      logic [1:0] bw;
      ch = int'(VEC[v][30:28]); src = int'(VEC[v][27:20]); dst = int'(VEC[v][19:12]);
      len = int'(VEC[v][11:4]); si = VEC[v][3]; di = VEC[v][2]; bw = VEC[v][1:0];
      n = (len == 0) ? 256 : len;
      init_mem();
      for (int k = 0; k < n; k++)
        model[8'(dst + (di ? k : 0))] = ival(8'(src + (si ? k : 0)));
      bw_sel = bw;
      cfg(ch, 0, src); cfg(ch, 1, dst); cfg(ch, 2, len);
      clr_stats();
      cfg(ch, 3, 1 | (int'(si) << 1) | (int'(di) << 2) | 8);
      dreq[ch] = 1'b1;
      wait_done(ch, 2000);
      dreq[ch] = 1'b0;
      @(negedge clk);
      mism = 0;
      for (int a = 0; a < 256; a++) if (mem[a] !== model[a]) mism++;
      chk(mism == 0, "R1 R2 data", mism, 0);
      chk(rd_cnt == n, "R3 byte count", rd_cnt, n);
      chk(pair_err == 0, "R1 read/write pairing", pair_err, 0);
      chk(maxw <= int'(bw) + 1, "R4 window cap", maxw, int'(bw) + 1);
      if (bw == 2'd3)
        chk(last_rd - first_rd == 2 * (n - 1), "R4 back to back", last_rd - first_rd, 2 * (n - 1));
      chk(irq[ch] == 1'b1, "R7 irq raised", int'(irq[ch]), 1);
      cfg(ch, 3, 16);
      @(negedge clk);
      chk(done[ch] == 1'b0 && irq[ch] == 1'b0, "R8 write-1 clear", int'({done[ch], irq[ch]}), 0);
    end

    // R3: length field 0 moves 256 bytes
    bw_sel = 2'd3;
    cfg(2, 0, 8'h05); cfg(2, 1, 8'hFF); cfg(2, 2, 0);
    clr_stats();
    cfg(2, 3, 1);
    dreq[2] = 1'b1;
    wait_done(2, 2000);
    dreq[2] = 1'b0;
    chk(rd_cnt == 256, "R3 zero means 256", rd_cnt, 256);
    chk(mem[8'hFF] == ival(5), "R2 fixed pointers", int'(mem[8'hFF]), int'(ival(5)));
    // R7: no interrupt when its enable is clear
    chk(done[2] == 1'b1 && irq[2] == 1'b0, "R7 irq masked", int'(irq[2]), 0);
    // R8: enable write clears done
    cfg(2, 2, 1);
    cfg(2, 3, 1);
    @(negedge clk);
    chk(done[2] == 1'b0, "R8 enable clears done", int'(done[2]), 0);
    cfg(2, 3, 0);

    // R5: fixed priority, lower channel first, bytes not interleaved
    init_mem();
    cfg(1, 0, 8'h10); cfg(1, 1, 8'h50); cfg(1, 2, 2); cfg(1, 3, 7);
    cfg(2, 0, 8'h20); cfg(2, 1, 8'h60); cfg(2, 2, 2); cfg(2, 3, 7);
    clr_stats();
    @(negedge clk);
    dreq = 4'b0110;
    wait_done(1, 200);
    wait_done(2, 200);
    dreq = '0;
    chk(rd_log[0] == 16'h10 && rd_log[1] == 16'h11, "R5 low channel first",
        int'(rd_log[0]), 16'h10);
    chk(rd_log[2] == 16'h20 && rd_log[3] == 16'h21, "R5 then next channel",
        int'(rd_log[2]), 16'h20);
    cfg(1, 3, 16); cfg(2, 3, 16);

    // R9: held during CPU wait with wait operation disabled
    cpu_wait = 1'b1; wait_en = 1'b0;
    cfg(0, 0, 8'h00); cfg(0, 1, 8'hA0); cfg(0, 2, 2);
    clr_stats();
    cfg(0, 3, 7);
    dreq[0] = 1'b1;
    repeat (40) @(negedge clk);
    chk(rd_cnt == 0 && bus_req == 1'b0, "R9 held in wait", rd_cnt, 0);
    wait_en = 1'b1;
    wait_done(0, 200);
    chk(rd_cnt == 2, "R9 runs in wait when enabled", rd_cnt, 2);
    dreq[0] = 1'b0; cpu_wait = 1'b0; wait_en = 1'b0;
    cfg(0, 3, 16);

    // R6: no bus use without grant
    bus_grant = 1'b0;
    cfg(3, 0, 8'h00); cfg(3, 1, 8'hB0); cfg(3, 2, 3);
    clr_stats();
    cfg(3, 3, 7);
    dreq[3] = 1'b1;
    repeat (20) @(negedge clk);
    chk(rd_cnt == 0 && bus_req == 1'b1, "R6 waits for grant", rd_cnt, 0);
    bus_grant = 1'b1;
    wait_done(3, 200);
    @(negedge clk);
    chk(bus_req == 1'b0, "R6 request dropped when idle", int'(bus_req), 0);
    dreq[3] = 1'b0;
    cfg(3, 3, 16);

    // R8: completion and a clear write on the same edge; completion wins
    cfg(0, 0, 8'h01); cfg(0, 1, 8'hC0); cfg(0, 2, 1);
    cfg(0, 3, 15);
    dreq[0] = 1'b1;
    begin
      int n = 0;
      @(negedge clk);
      while (!bus_wr && n < 100) begin @(negedge clk); n++; end
    end
    cfg_we = 1'b1; cfg_chan = 2'd0; cfg_fld = 2'd3; cfg_wdata = 16'd16;
    @(negedge clk);
    cfg_we = 1'b0;
    dreq[0] = 1'b0;
    chk(done[0] == 1'b1, "R8 set beats clear", int'(done[0]), 1);
    cfg(0, 3, 16);
    @(negedge clk);
    chk(done[0] == 1'b0, "R8 later clear", int'(done[0]), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule